// File: doc/BRIEF.md
# Two-Client Memory Request Arbiter

This block lets two clients share one single-port memory controller. One client only reads (the video output path, which refills its buffer from memory). The other only writes (the video capture path, which drains its buffer into memory). The controller accepts one command at a time. It answers with an acknowledge, then a per-word strobe for each data word, then an end-of-burst pulse. The arbiter stays idle until the controller says its start-up sequence is complete. From then on it looks at both request lines in the same cycle and picks one client. It issues a single read or write command with that client's address and sends the controller's per-word strobes only to that client. It takes no further request until the burst has ended.

Clients are indexed internally, and a lower index means a higher priority. The read client is index 0. Each client's direction comes from a parameter mask. Adding a client therefore means adding one more request, address and strobe lane, with no change to the state machine.

Top module: `memreq_arbiter2`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `mem_cmd_valid`, both grant outputs and both forwarded strobe outputs are 0.
- R2: Until `mem_init_done` has been seen high, no request is sampled. `mem_cmd_valid` and both grants stay 0 whatever the request inputs do.
- R3: When both clients request in the same polling cycle, the read client wins. The next cycle shows `mem_cmd_valid`=1, `mem_cmd_write`=0 and `mem_cmd_addr` equal to `rd_addr`.
- R4: When only the write client requests, the next cycle shows `mem_cmd_valid`=1, `mem_cmd_write`=1 and `mem_cmd_addr` equal to `wr_addr`.
- R5: With no request, the arbiter keeps polling and issues nothing. A request that is first present at a polling clock edge produces a command in the cycle right after that edge.
- R6: `mem_cmd_valid`, `mem_cmd_write` and `mem_cmd_addr` stay constant from the first command cycle up to and including the cycle in which `mem_cmd_ack` is 1. `mem_cmd_valid` is 0 in the cycle after the acknowledge.
- R7: The winner's grant output is 1 for exactly one cycle, and that cycle is the first command cycle. The other client's grant stays 0.
- R8: While a transaction is open (from the first command cycle until end of burst), `mem_wr_pop` is passed through on `wr_pop` only if the write client owns the transaction. Likewise `mem_rd_valid` reaches `rd_valid` only if the read client owns it. In every other case both outputs are 0, including when no transaction is open.
- R9: After the acknowledge, no request is sampled until `mem_burst_done` is 1. The next command appears no earlier than two cycles after the `mem_burst_done` cycle.
- R10: Once initialization has been seen complete, later changes on `mem_init_done` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_init_done | input | 1 | Controller start-up finished |
| rd_req | input | 1 | Read client requests a burst |
| rd_addr | input | ADDR_W | Read client burst address |
| wr_req | input | 1 | Write client requests a burst |
| wr_addr | input | ADDR_W | Write client burst address |
| mem_cmd_ack | input | 1 | Controller accepted the command |
| mem_wr_pop | input | 1 | Controller takes one write word |
| mem_rd_valid | input | 1 | Controller presents one read word |
| mem_burst_done | input | 1 | Controller finished the burst |
| mem_cmd_valid | output | 1 | Command request to controller |
| mem_cmd_write | output | 1 | 1 = write, 0 = read |
| mem_cmd_addr | output | ADDR_W | Command address |
| rd_grant | output | 1 | One-cycle grant to read client |
| wr_grant | output | 1 | One-cycle grant to write client |
| rd_valid | output | 1 | Read word strobe to read client |
| wr_pop | output | 1 | Write word strobe to write client |

## Verification
A wrong owner register shows up within the first burst cycle. Strobes then reach the idle client, or the direction bit no longer matches the address that was sent. A state machine that leaves the acknowledge wait too early drops `mem_cmd_valid` one cycle before the acknowledge. One that skips the end-of-burst wait issues a second command while the first burst is still running, one cycle after the acknowledge. A broken priority order appears in the very first command after a cycle in which both clients request together.

// File: rtl/memarb_pkg.sv
package memarb_pkg;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_POLL  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_BURST = 2'd3
    } arb_state_e;

    // True when the state holds an open transaction.
    function automatic logic state_open(arb_state_e s);
        return (s == ST_ISSUE) || (s == ST_BURST);
    endfunction

endpackage

// File: rtl/memarb_pick.sv
module memarb_pick #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] win,
    output logic         any
);
    // Fixed priority: lowest index wins.
    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            win[i] = req[i] & ~taken;
            taken  = taken | req[i];
        end
        any = taken;
    end
endmodule

// File: rtl/memarb_fsm.sv
module memarb_fsm
    import memarb_pkg::*;
#(
    parameter int          N          = 2,
    parameter int          ADDR_W     = 22,
    parameter logic [N-1:0] WRITE_MASK = 2'b10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   init_done,
    input  logic [N-1:0]           req,
    input  logic [N-1:0][ADDR_W-1:0] addr,
    input  logic                   ack,
    input  logic                   done,
    output logic                   cmd_valid,
    output logic                   cmd_write,
    output logic [ADDR_W-1:0]      cmd_addr,
    output logic [N-1:0]           grant,
    output logic [N-1:0]           owner,
    output logic                   open
);
    arb_state_e        state;
    logic [N-1:0]      win;
    logic              any;
    logic [ADDR_W-1:0] win_addr;

    memarb_pick #(.N(N)) u_pick (
        .req (req),
        .win (win),
        .any (any)
    );

    always_comb begin
        win_addr = '0;
        for (int i = 0; i < N; i++) begin
            win_addr = win_addr | (addr[i] & {ADDR_W{win[i]}});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_INIT;
            owner     <= '0;
            cmd_addr  <= '0;
            cmd_write <= 1'b0;
            grant     <= '0;
        end else begin
            grant <= '0;
            case (state)
                ST_INIT:  if (init_done) state <= ST_POLL;
                ST_POLL: begin
                    if (any) begin
                        owner     <= win;
                        cmd_addr  <= win_addr;
                        cmd_write <= |(win & WRITE_MASK);
                        grant     <= win;
                        state     <= ST_ISSUE;
                    end
                end
                ST_ISSUE: if (ack)  state <= ST_BURST;
                ST_BURST: if (done) state <= ST_POLL;
                default:  state <= ST_INIT;
            endcase
        end
    end

    assign cmd_valid = (state == ST_ISSUE);
    assign open      = state_open(state);

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !ack) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_write))); // R6
    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (rst)
        (|grant) |=> !(|grant)); // R7
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R7
    AST_READER_FIRST: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POLL && req[0]) |=> grant[0]); // R3
    AST_NO_EARLY_CMD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INIT && !init_done) |=> !cmd_valid); // R2
    AST_BURST_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BURST && !done) |=> !cmd_valid); // R9
endmodule

// File: rtl/memarb_route.sv
module memarb_route #(
    parameter int           N          = 2,
    parameter logic [N-1:0] WRITE_MASK = 2'b10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] owner,
    input  logic         open,
    input  logic         pop_in,
    input  logic         valid_in,
    output logic [N-1:0] pop_out,
    output logic [N-1:0] valid_out
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        if (WRITE_MASK[i]) begin : g_wr
            assign pop_out[i]   = open & owner[i] & pop_in;
            assign valid_out[i] = 1'b0;
        end else begin : g_rd
            assign pop_out[i]   = 1'b0;
            assign valid_out[i] = open & owner[i] & valid_in;
        end
    end

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pop_out | valid_out)); // R8
endmodule

// File: rtl/memreq_arbiter2.sv
module memreq_arbiter2 #(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_init_done,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              mem_cmd_ack,
    input  logic              mem_wr_pop,
    input  logic              mem_rd_valid,
    input  logic              mem_burst_done,
    output logic              mem_cmd_valid,
    output logic              mem_cmd_write,
    output logic [ADDR_W-1:0] mem_cmd_addr,
    output logic              rd_grant,
    output logic              wr_grant,
    output logic              rd_valid,
    output logic              wr_pop
);
    localparam int           N     = 2;
    localparam logic [N-1:0] WMASK = 2'b10;  // lane 0 reads, lane 1 writes

    logic [N-1:0]             req_v;
    logic [N-1:0][ADDR_W-1:0] addr_v;
    logic [N-1:0]             grant_v, owner_v, pop_v, valid_v;
    logic                     open;

    assign req_v  = {wr_req, rd_req};
    assign addr_v = {wr_addr, rd_addr};

    memarb_fsm #(.N(N), .ADDR_W(ADDR_W), .WRITE_MASK(WMASK)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .init_done (mem_init_done),
        .req       (req_v),
        .addr      (addr_v),
        .ack       (mem_cmd_ack),
        .done      (mem_burst_done),
        .cmd_valid (mem_cmd_valid),
        .cmd_write (mem_cmd_write),
        .cmd_addr  (mem_cmd_addr),
        .grant     (grant_v),
        .owner     (owner_v),
        .open      (open)
    );

    memarb_route #(.N(N), .WRITE_MASK(WMASK)) u_route (
        .clk       (clk),
        .rst       (rst),
        .owner     (owner_v),
        .open      (open),
        .pop_in    (mem_wr_pop),
        .valid_in  (mem_rd_valid),
        .pop_out   (pop_v),
        .valid_out (valid_v)
    );

    assign rd_grant = grant_v[0];
    assign wr_grant = grant_v[1];
    assign rd_valid = valid_v[0];
    assign wr_pop   = pop_v[1];

    AST_CMD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cmd_valid) |-> $past(rd_req || wr_req)); // R5
    AST_WRITE_TO_WRITER: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && mem_cmd_write) |-> !rd_grant); // R4
endmodule

// File: tb/memreq_arbiter2_bench.sv
module memreq_arbiter2_bench;
    localparam int AW = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_done = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0;
    logic ack = 1'b0, pop_in = 1'b0, val_in = 1'b0, done = 1'b0;
    logic cmd_valid, cmd_write, rd_grant, wr_grant, rd_valid, wr_pop;
    logic [AW-1:0] cmd_addr;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    memreq_arbiter2 #(.ADDR_W(AW)) u_memreq_arbiter2 (
        .clk(clk), .rst(rst), .mem_init_done(init_done),
        .rd_req(rd_req), .rd_addr(rd_addr), .wr_req(wr_req), .wr_addr(wr_addr),
        .mem_cmd_ack(ack), .mem_wr_pop(pop_in), .mem_rd_valid(val_in),
        .mem_burst_done(done), .mem_cmd_valid(cmd_valid), .mem_cmd_write(cmd_write),
        .mem_cmd_addr(cmd_addr), .rd_grant(rd_grant), .wr_grant(wr_grant),
        .rd_valid(rd_valid), .wr_pop(wr_pop)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic quiet(string tag);
        chk({tag, " cmd_valid"}, 32'(cmd_valid), 0);
        chk({tag, " grants"}, 32'({rd_grant, wr_grant}), 0);
        chk({tag, " strobes"}, 32'({rd_valid, wr_pop}), 0);
    endtask

    task automatic t_reset();
        repeat (3) step();
        quiet("R1 in reset");
        rst = 1'b0;
        step();
        quiet("R1 after reset");
    endtask

    task automatic t_init_gate();
        rd_req = 1; wr_req = 1; rd_addr = 22'h0A5A5; wr_addr = 22'h13C3C;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R2 no cmd before init", 32'(cmd_valid), 0);
            chk("R2 no grant before init", 32'({rd_grant, wr_grant}), 0);
        end
        init_done = 1;
        step();                       // leaves init wait, now polling
        chk("R2 poll cycle", 32'(cmd_valid), 0);
    endtask

    task automatic t_both_reader_first();
        step();                       // both sampled at this edge
        chk("R3 cmd_valid", 32'(cmd_valid), 1);
        chk("R3 read dir", 32'(cmd_write), 0);
        chk("R3 addr", 32'(cmd_addr), 32'(rd_addr));
        chk("R7 rd_grant pulse", 32'(rd_grant), 1);
        chk("R7 wr_grant idle", 32'(wr_grant), 0);
        rd_req = 0;
        init_done = 0;                // R10: must have no effect from now on
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R6 held valid", 32'(cmd_valid), 1);
            chk("R6 held addr", 32'(cmd_addr), 32'h0A5A5);
            chk("R6 held dir", 32'(cmd_write), 0);
            chk("R7 grant gone", 32'({rd_grant, wr_grant}), 0);
        end
        val_in = 1; #1;
        chk("R8 read strobe in issue", 32'(rd_valid), 1);
        val_in = 0;
        ack = 1;
        step();
        ack = 0;
        chk("R6 valid drops after ack", 32'(cmd_valid), 0);
        val_in = 1; pop_in = 1; #1;
        chk("R8 rd_valid to owner", 32'(rd_valid), 1);
        chk("R8 wr_pop blocked", 32'(wr_pop), 0);
        val_in = 0; pop_in = 0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R9 no cmd during burst", 32'(cmd_valid), 0);
        end
        done = 1;
        step();
        done = 0;
        chk("R9 poll after done", 32'(cmd_valid), 0);
    endtask

    task automatic t_writer_alone();
        step();                       // wr_req still high, init_done low (R10)
        chk("R4/R10 cmd_valid", 32'(cmd_valid), 1);
        chk("R4 write dir", 32'(cmd_write), 1);
        chk("R4 addr", 32'(cmd_addr), 32'h13C3C);
        chk("R7 wr_grant pulse", 32'({rd_grant, wr_grant}), 32'b01);
        wr_req = 0;
        ack = 1;
        step();
        ack = 0;
        pop_in = 1; val_in = 1; #1;
        chk("R8 wr_pop to owner", 32'(wr_pop), 1);
        chk("R8 rd_valid blocked", 32'(rd_valid), 0);
        pop_in = 0; val_in = 0;
        done = 1;
        step();
        done = 0;
    endtask

    task automatic t_idle_then_req();
        for (int i = 0; i < 4; i++) begin
            step();
            quiet("R5 idle");
        end
        pop_in = 1; val_in = 1; #1;
        chk("R8 no strobes when idle", 32'({rd_valid, wr_pop}), 0);
        pop_in = 0; val_in = 0;
        rd_addr = 22'h3FFFF;
        rd_req = 1;
        step();
        chk("R5 served next cycle", 32'(cmd_valid), 1);
        chk("R5 addr", 32'(cmd_addr), 32'h3FFFF);
        rd_req = 0;
        ack = 1; step(); ack = 0;
        done = 1; step(); done = 0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2;
        t_reset();
        t_init_gate();
        t_both_reader_first();
        t_writer_alone();
        t_idle_then_req();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule